// File: doc/BRIEF.md
# Windowed Bank-Switching Address Mapper

The mapper sits between a host CPU with a 16-bit word address and a private 64K-word, 16-bit memory. The host space is cut into 32 windows of 2K words, selected by the five top address bits. Each window carries a read enable, a write enable and a relocation enable, together with a low trim and a high trim counted in 256-word pages. A window without relocation passes the host address through unchanged. A relocated window adds its own 8-bit bank value, shifted up by eight bits, to the 11-bit offset inside the window. Because this is an addition, the window can start on any 256-word boundary of the private memory.

Software sets the bank values through 32 write-only registers that occupy a small block of host addresses. Window attributes are loaded through a separate configuration port, one window per cycle. Accesses that fall outside a responding span, or that break a window's attributes, get no response. This leaves the bus free for other devices. The private memory has one cycle of read latency, and the host sees both the response flag and the read data one cycle after its strobe.

Top module: `win_bank_map`

## Requirements
- R1: After reset every window is disabled (no response anywhere), all bank values are zero, and host_ack_o and host_rdata_o are 0.
- R2: A window responds to reads only when its read enable is set and to writes only when its write enable is set; a rejected write leaves memory unchanged and a window with neither enable never responds.
- R3: With page = host_addr_i[10:8], low trim L and high trim H, a window responds only when L <= page and page + H <= 7; outside that span there is no response and no memory access.
- R4: In a window whose relocation enable is clear, the memory address equals the host address.
- R5: In a relocated window the memory address is (host_addr_i & 16'h07FF) + (bank << 8), taken modulo 2^16 (bank $38 at $6123 gives $3923, bank $FF at $6700 gives $0600).
- R6: A host write to $0040..$005F loads bank register 2*host_addr_i[3:0] + host_addr_i[4] (so $0040+n serves window 2n and $0050+n serves window 2n+1) with host_wdata_i[7:0]; bits 15:8 are discarded.
- R7: A host write to the bank register block performs no memory write and gives no response, even when window 0 is mapped writeable.
- R8: A bank value changes translation only for its own window and only while that window is relocated; several windows may reach the same memory words, each with its own attributes.
- R9: host_ack_o and the read data on host_rdata_o appear exactly one cycle after the strobe; host_rdata_o is 0 in any cycle without a read response.
- R10: A configuration write loads one window entry (read enable, write enable, relocation enable, 3-bit low trim, 3-bit high trim) and takes effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration entry write strobe |
| cfg_win_i | input | 5 | Window index to configure |
| cfg_rd_en_i | input | 1 | Read enable for the entry |
| cfg_wr_en_i | input | 1 | Write enable for the entry |
| cfg_bank_en_i | input | 1 | Relocation enable for the entry |
| cfg_lo_trim_i | input | 3 | Pages trimmed from the window's low end |
| cfg_hi_trim_i | input | 3 | Pages trimmed from the window's high end |
| host_addr_i | input | 16 | Host word address |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Read data, valid with host_ack_o |
| host_ack_o | output | 1 | Mapper responded to the access of the previous cycle |
| mem_addr_o | output | 16 | Private memory address |
| mem_re_o | output | 1 | Private memory read enable |
| mem_we_o | output | 1 | Private memory write enable |
| mem_wdata_o | output | 16 | Private memory write data |
| mem_rdata_i | input | 16 | Private memory read data, one cycle after mem_re_o |

## Verification
Translation is exercised with bank values of $00, $38, $3F, $FF, $12 and $68. Each one separates a true addition from a bit replacement, and $FF also checks the wrap at 2^16. Unwritten memory words hold an address-dependent pattern, so a read returns a value that identifies the word it came from. Writes through a relocated window are then read back through a direct window onto the same words, which confirms the overlap. Trim pairs are chosen to show low-only, low-and-high, empty and high-only spans at their page boundaries. Bank writes are made with garbage in the upper byte, to both interleaved halves of the register block, and with window 0 mapped writeable, so that the register path is shown to be separate from the memory path.

// File: rtl/win_map_pkg.sv
package win_map_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned WIN_BITS  = 5;
  localparam int unsigned PAGE_BITS = 3;
  localparam int unsigned PAGE_LSB  = 8;
  localparam int unsigned BANK_W    = ADDR_W - PAGE_LSB;
  localparam int unsigned NUM_WIN   = 1 << WIN_BITS;
  localparam int unsigned OFF_W     = ADDR_W - WIN_BITS;

  typedef struct packed {
    logic                 rd_en;
    logic                 wr_en;
    logic                 bank_en;
    logic [PAGE_BITS-1:0] lo_trim;
    logic [PAGE_BITS-1:0] hi_trim;
  } win_cfg_t;
endpackage

// File: rtl/win_cfg_table.sv
module win_cfg_table
  import win_map_pkg::*;
#(
  parameter int unsigned N_WIN = NUM_WIN,
  localparam int unsigned IDX_W = $clog2(N_WIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  win_cfg_t         entry_i,
  input  logic [IDX_W-1:0] ridx_i,
  output win_cfg_t         entry_o
);
  win_cfg_t tbl [N_WIN];

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tbl[w] <= '0;
      else if (we_i && widx_i == IDX_W'(w)) tbl[w] <= entry_i;
    end
  end

  assign entry_o = tbl[ridx_i];
endmodule

// File: rtl/bank_reg_file.sv
module bank_reg_file
  import win_map_pkg::*;
#(
  parameter int unsigned N_WIN = NUM_WIN,
  parameter int unsigned BW    = BANK_W,
  localparam int unsigned IDX_W = $clog2(N_WIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [BW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [BW-1:0]    bank_o
);
  logic [BW-1:0] regs [N_WIN];

  for (genvar w = 0; w < N_WIN; w++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs[w] <= '0;
      else if (we_i && widx_i == IDX_W'(w)) regs[w] <= wdata_i;
    end
  end

  assign bank_o = regs[ridx_i];
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import win_map_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned OW = OFF_W,
  parameter int unsigned PL = PAGE_LSB,
  parameter int unsigned BW = BANK_W,
  localparam int unsigned PW = OW - PL
) (
  input  logic [AW-1:0] addr_i,
  input  win_cfg_t      cfg_i,
  input  logic [BW-1:0] bank_i,
  output logic          rd_ok_o,
  output logic          wr_ok_o,
  output logic [AW-1:0] cart_o
);
  localparam logic [PW:0] PAGE_MAX = (PW+1)'((1 << PW) - 1);

  logic [PW-1:0] page;
  logic          in_span;

  assign page    = addr_i[OW-1:PL];
  // span test written without subtraction so an oversized trim empties the window
  assign in_span = (page >= cfg_i.lo_trim) &&
                   (({1'b0, page} + {1'b0, cfg_i.hi_trim}) <= PAGE_MAX);

  assign rd_ok_o = in_span & cfg_i.rd_en;
  assign wr_ok_o = in_span & cfg_i.wr_en;

  always_comb begin
    if (cfg_i.bank_en) cart_o = AW'(addr_i[OW-1:0]) + AW'({bank_i, {PL{1'b0}}});
    else               cart_o = addr_i;
  end
endmodule

// File: rtl/win_bank_map.sv
module win_bank_map
  import win_map_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h0040
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [WIN_BITS-1:0]  cfg_win_i,
  input  logic                 cfg_rd_en_i,
  input  logic                 cfg_wr_en_i,
  input  logic                 cfg_bank_en_i,
  input  logic [PAGE_BITS-1:0] cfg_lo_trim_i,
  input  logic [PAGE_BITS-1:0] cfg_hi_trim_i,
  input  logic [ADDR_W-1:0]    host_addr_i,
  input  logic                 host_rd_i,
  input  logic                 host_wr_i,
  input  logic [DATA_W-1:0]    host_wdata_i,
  output logic [DATA_W-1:0]    host_rdata_o,
  output logic                 host_ack_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic                 mem_re_o,
  output logic                 mem_we_o,
  output logic [DATA_W-1:0]    mem_wdata_o,
  input  logic [DATA_W-1:0]    mem_rdata_i
);
  win_cfg_t            cfg_wr_entry, cur_cfg;
  logic [WIN_BITS-1:0] cur_win, reg_win;
  logic [BANK_W-1:0]   cur_bank;
  logic                reg_hit, reg_we, rd_ok, wr_ok, rd_go, wr_go;
  logic                ack_q, rd_q;

  assign cfg_wr_entry = '{rd_en: cfg_rd_en_i, wr_en: cfg_wr_en_i, bank_en: cfg_bank_en_i,
                          lo_trim: cfg_lo_trim_i, hi_trim: cfg_hi_trim_i};

  assign cur_win = host_addr_i[ADDR_W-1 -: WIN_BITS];
  assign reg_hit = host_addr_i[ADDR_W-1:WIN_BITS] == REG_BASE[ADDR_W-1:WIN_BITS];
  // interleaved map: low nibble picks the 4K pair, bit 4 picks the upper half
  assign reg_win = {host_addr_i[WIN_BITS-2:0], host_addr_i[WIN_BITS-1]};
  assign reg_we  = host_wr_i & ~host_rd_i & reg_hit;

  win_cfg_table u_cfg (
    .clk_i, .rst_ni,
    .we_i    (cfg_we_i),
    .widx_i  (cfg_win_i),
    .entry_i (cfg_wr_entry),
    .ridx_i  (cur_win),
    .entry_o (cur_cfg)
  );

  bank_reg_file u_bank (
    .clk_i, .rst_ni,
    .we_i    (reg_we),
    .widx_i  (reg_win),
    .wdata_i (host_wdata_i[BANK_W-1:0]),
    .ridx_i  (cur_win),
    .bank_o  (cur_bank)
  );

  addr_xlate u_xlate (
    .addr_i  (host_addr_i),
    .cfg_i   (cur_cfg),
    .bank_i  (cur_bank),
    .rd_ok_o (rd_ok),
    .wr_ok_o (wr_ok),
    .cart_o  (mem_addr_o)
  );

  assign rd_go       = host_rd_i & rd_ok;
  assign wr_go       = host_wr_i & ~host_rd_i & ~reg_hit & wr_ok;
  assign mem_re_o    = rd_go;
  assign mem_we_o    = wr_go;
  assign mem_wdata_o = host_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      ack_q <= rd_go | wr_go;
      rd_q  <= rd_go;
    end
  end

  assign host_ack_o   = ack_q;
  assign host_rdata_o = rd_q ? mem_rdata_i : '0;
endmodule

// File: rtl/win_bank_map_chk.sv
module win_bank_map_chk #(
  parameter logic [15:0] REG_BASE = 16'h0040
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] host_addr_i,
  input logic        host_rd_i,
  input logic        host_wr_i,
  input logic [15:0] host_rdata_o,
  input logic        host_ack_o,
  input logic        mem_re_o,
  input logic        mem_we_o
);
  logic reg_wr;
  assign reg_wr = host_wr_i && !host_rd_i && (host_addr_i[15:5] == REG_BASE[15:5]);

  a_r7_reg_wr_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr |-> !mem_we_o);
  a_r7_reg_wr_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr |=> !host_ack_o);
  a_r9_ack_after_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |-> $past(mem_re_o || mem_we_o));
  a_r9_rdata_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_ack_o |-> host_rdata_o == 16'h0);
  a_r2_mem_one_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  a_r9_no_strobe_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_rd_i || host_wr_i) |-> !(mem_re_o || mem_we_o));
endmodule

bind win_bank_map win_bank_map_chk #(.REG_BASE(REG_BASE)) u_chk (
  .clk_i, .rst_ni, .host_addr_i, .host_rd_i, .host_wr_i,
  .host_rdata_o, .host_ack_o, .mem_re_o, .mem_we_o
);

// File: tb/win_bank_map_test.sv
`timescale 1ns/1ps
module win_bank_map_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [4:0]  cfg_win_i = '0;
  logic        cfg_rd_en_i = 1'b0, cfg_wr_en_i = 1'b0, cfg_bank_en_i = 1'b0;
  logic [2:0]  cfg_lo_trim_i = '0, cfg_hi_trim_i = '0;
  logic [15:0] host_addr_i = '0;
  logic        host_rd_i = 1'b0, host_wr_i = 1'b0;
  logic [15:0] host_wdata_i = '0;
  logic [15:0] host_rdata_o;
  logic        host_ack_o;
  logic [15:0] mem_addr_o, mem_wdata_o;
  logic        mem_re_o, mem_we_o;
  logic [15:0] mem_rdata_i = '0;

  always #2.5 clk_i = ~clk_i;

  win_bank_map uut (.*);

  int errors = 0, checks = 0;

  function automatic logic [15:0] fill(input int a);
    return 16'(a) ^ 16'h5A3C;
  endfunction

  // memory attached to the DUT
  logic [15:0] bmem [int];
  always @(posedge clk_i) begin
    if (mem_re_o) mem_rdata_i <= bmem.exists(int'(mem_addr_o)) ? bmem[int'(mem_addr_o)] : fill(int'(mem_addr_o));
    if (mem_we_o) bmem[int'(mem_addr_o)] = mem_wdata_o;
  end

  // reference model state
  logic [15:0] rmem [int];
  int m_rd [32], m_wr [32], m_bk [32], m_lo [32], m_hi [32], m_bank [32];

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cfg(input int w, input int r, input int wr, input int bk, input int lo, input int hi);
    cfg_we_i = 1'b1; cfg_win_i = 5'(w);
    cfg_rd_en_i = 1'(r); cfg_wr_en_i = 1'(wr); cfg_bank_en_i = 1'(bk);
    cfg_lo_trim_i = 3'(lo); cfg_hi_trim_i = 3'(hi);
    m_rd[w] = r; m_wr[w] = wr; m_bk[w] = bk; m_lo[w] = lo; m_hi[w] = hi;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // one host access, checked one cycle later
  task automatic acc(input string tag, input bit rd, input int addr, input int wd);
    int w, off, pg, ca;
    bit hit, ack;
    logic [15:0] erd;
    host_rd_i = rd; host_wr_i = !rd; host_addr_i = 16'(addr); host_wdata_i = 16'(wd);
    erd = '0; ack = 0;
    if (!rd && addr >= 'h40 && addr <= 'h5F) begin
      int r = addr - 'h40;
      int tw = (r < 16) ? 2*r : 2*(r-16)+1;
      m_bank[tw] = wd % 256;
    end else begin
      w = addr / 2048; off = addr % 2048; pg = off / 256;
      hit = (pg >= m_lo[w]) && (pg <= 7 - m_hi[w]);
      ca = m_bk[w] != 0 ? (off + m_bank[w]*256) % 65536 : addr;
      if (rd && hit && m_rd[w] != 0) begin
        ack = 1;
        erd = rmem.exists(ca) ? rmem[ca] : fill(ca);
      end
      if (!rd && hit && m_wr[w] != 0) begin
        ack = 1;
        rmem[ca] = 16'(wd);
      end
    end
    @(negedge clk_i);
    host_rd_i = 1'b0; host_wr_i = 1'b0;
    check(tag, 16'(host_ack_o), 16'(ack), $sformatf("ack @%h", addr[15:0]));
    check(tag, host_rdata_o, erd, $sformatf("rdata @%h", addr[15:0]));
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    foreach (m_rd[i]) begin m_rd[i]=0; m_wr[i]=0; m_bk[i]=0; m_lo[i]=0; m_hi[i]=0; m_bank[i]=0; end
    repeat (3) @(negedge clk_i);
    check("R1", 16'(host_ack_o), 16'h0, "ack in reset");
    check("R1", host_rdata_o, 16'h0, "rdata in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: nothing responds after reset
    acc("R1", 1, 'h5000, 0);
    acc("R1", 0, 'hC123, 'h1234);
    // R1: zero bank value after reset; R10 entry active next cycle
    cfg(12, 1, 1, 1, 0, 0);
    acc("R1", 1, 'h6123, 0);
    // R4 direct RAM window
    cfg(10, 1, 1, 0, 0, 0);
    acc("R4", 0, 'h5123, 'h1111);
    acc("R4", 1, 'h5123, 0);
    acc("R9", 1, 'h57FF, 0);
    // R5/R6 bank $38, upper byte discarded
    acc("R6", 0, 'h0046, 'hAB38);
    acc("R5", 1, 'h6123, 0);
    acc("R5", 0, 'h6123, 'h2222);
    // R8 overlap seen through direct window 7
    cfg(7, 1, 0, 0, 0, 0);
    acc("R8", 1, 'h3923, 0);
    acc("R5", 0, 'h0046, 'h003F);
    acc("R5", 1, 'h6123, 0);
    // R5 wrap
    acc("R5", 0, 'h0046, 'h00FF);
    acc("R5", 0, 'h6700, 'h3333);
    cfg(0, 1, 1, 0, 0, 0);
    acc("R5", 1, 'h0600, 0);
    // R7 register write with window 0 writeable
    acc("R7", 0, 'h0045, 'h4444);
    acc("R7", 1, 'h0045, 0);
    // R8 bank value ignored by non-relocated window 10
    acc("R8", 1, 'h5123, 0);
    // R6 interleaved halves
    acc("R6", 0, 'h0053, 'hFF12);
    cfg(7, 1, 0, 1, 0, 0);
    acc("R6", 1, 'h3900, 0);
    acc("R6", 0, 'h0047, 'h0050);
    cfg(14, 1, 0, 1, 0, 0);
    acc("R6", 1, 'h7000, 0);
    // R2 ROM, write-only and disabled windows
    cfg(11, 1, 0, 0, 0, 0);
    acc("R2", 0, 'h5801, 'h5555);
    acc("R2", 1, 'h5801, 0);
    cfg(13, 0, 1, 0, 0, 0);
    acc("R2", 1, 'h6805, 0);
    acc("R2", 0, 'h6805, 'h6666);
    acc("R2", 0, 'h0046, 'h0068);
    acc("R2", 1, 'h6005, 0);
    acc("R2", 1, 'h4800, 0);
    acc("R2", 0, 'h4800, 'h7777);
    // R3 trims
    cfg(1, 1, 1, 0, 5, 0);
    acc("R3", 1, 'h0CFF, 0);
    acc("R3", 1, 'h0D00, 0);
    acc("R3", 1, 'h0FFF, 0);
    acc("R3", 0, 'h0C10, 'h8888);
    cfg(1, 1, 1, 0, 5, 2);
    acc("R3", 1, 'h0DFF, 0);
    acc("R3", 1, 'h0E00, 0);
    cfg(1, 1, 1, 0, 6, 3);
    acc("R3", 1, 'h0E00, 0);
    acc("R3", 1, 'h0C00, 0);
    cfg(1, 1, 1, 0, 0, 7);
    acc("R3", 1, 'h0800, 0);
    acc("R3", 1, 'h0900, 0);
    acc("R3", 1, 'h0C10, 0);
    // R10 reconfigure to disabled takes effect at once
    cfg(10, 0, 0, 0, 0, 0);
    acc("R10", 1, 'h5123, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule